// File: doc/BRIEF.md
# Load-Use Stall and Squash Controller

This block is the hazard controller that sits on the decode/execute boundary of a five-stage, eight-opcode, in-order pipeline. It owns the opcode and target-register fields of the decode-to-execute pipeline register. From these fields it knows which instruction is in execute. It compares that instruction with the register fields of the instruction waiting in decode. When a load is in execute and its destination is a register that the decode instruction reads, the block raises `stall`. The surrounding pipeline uses `stall` to freeze the program counter and the fetch/decode register. During the same cycle the block writes a bubble into its own execute fields, so the stages from execute onward keep moving.

Branches and jumps are resolved in execute. A branch-if-equal whose equality flag is set, or any jump-and-link, raises `squash`. On `squash` the pipeline overwrites the fetch/decode register with a no-op, and the block overwrites its own execute fields with a bubble. The `pc_sel` output tells the program-counter multiplexer where the next fetch comes from. It selects the sequential address, the branch adder result, or the forwarded first source operand. Forwarding and the data-path multiplexers are not part of this block.

Opcode encoding, 3 bits: add 000, addi 001, nand 010, lui 011, sw 100, lw 101, beq 110, jalr 111. A bubble is opcode 000 with target 0.

Top module: `hzc_stall_squash_ctl`

## Requirements
- R1: While `rst_n` is low, `ex_op` is 000 and `ex_rt` is 0. This is asynchronous. As a result `stall` and `squash` are 0 and `pc_sel` is 00.
- R2: `stall` is 1 when all of the following hold: `ex_op` is lw (101), `ex_rt` is non-zero, `ex_rt` equals `dec_rb`, and `dec_op` is not lui (011). `stall` tells the pipeline to hold the PC and the fetch/decode register. If the decode instruction is held, the stall lasts exactly one cycle.
- R3: The second source of the decode instruction is `dec_rc` for add (000) and nand (010), and `dec_ra` for sw (100) and beq (110). A load target equal to that second source raises `stall`. A match on `dec_rc` or `dec_ra` under any other opcode does not raise it.
- R4: `stall` stays 0 when `ex_op` is not lw, and also when it is lw with `ex_rt` equal to 0.
- R5: After a clock edge at which `stall` was 1, `ex_op` is 000 and `ex_rt` is 0.
- R6: At a clock edge with neither `stall` nor `squash` high, `ex_op` takes `dec_op`. `ex_rt` takes `dec_ra` for add, addi, nand, lui, lw and jalr, and 0 for sw and beq.
- R7: When `ex_op` is beq (110) and `ex_eq` is 1, `squash` is 1 and `pc_sel` is 01 (branch target). When `ex_op` is beq and `ex_eq` is 0, both `squash` and `stall` are 0 and `pc_sel` is 00.
- R8: When `ex_op` is jalr (111), `squash` is 1 and `pc_sel` is 10 (jump target), whatever the value of `ex_eq`.
- R9: After a clock edge at which `squash` was 1, `ex_op` is 000 and `ex_rt` is 0. Whenever `squash` is 0, `pc_sel` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dec_op | input | 3 | Opcode of the instruction in decode |
| dec_ra | input | REG_W | rA field of the decode instruction |
| dec_rb | input | REG_W | rB field of the decode instruction |
| dec_rc | input | REG_W | rC field of the decode instruction |
| ex_eq | input | 1 | Equality flag of the execute-stage operands |
| stall | output | 1 | Hold the PC and fetch/decode register; bubble into execute |
| squash | output | 1 | Replace the fetch/decode and decode/execute contents with no-ops |
| pc_sel | output | 2 | Next-PC select: 00 PC+1, 01 branch target, 10 jump target |
| ex_op | output | 3 | Opcode field of the decode/execute register |
| ex_rt | output | REG_W | Target-register field of the decode/execute register |

## Verification
The only state in this block is the pair of execute fields, so a fault in that state shows up on `ex_op` and `ex_rt` one edge after the decode inputs are presented. Faults of this kind include a lost bubble, a wrong target for stores and branches, or a value that survives reset. A wrong execute opcode shows up as well, in the very cycle it is held. It appears as a missing or extra `stall`, or as a wrong `squash` or `pc_sel`. A dropped bubble can also appear as a stall that repeats on the held decode instruction. Each check therefore loads a known instruction into execute, presents a second instruction in decode, samples the combinational outputs, and then samples the execute fields after one more edge.

// File: rtl/hzc_pkg.sv
package hzc_pkg;

   localparam int OP_W    = 3;
   localparam int PCSEL_W = 2;

   typedef enum logic [OP_W-1:0] {
      OP_ADD  = 3'd0,
      OP_ADDI = 3'd1,
      OP_NAND = 3'd2,
      OP_LUI  = 3'd3,
      OP_SW   = 3'd4,
      OP_LW   = 3'd5,
      OP_BEQ  = 3'd6,
      OP_JALR = 3'd7
   } op_e;

   typedef enum logic [PCSEL_W-1:0] {
      PCS_SEQ    = 2'b00,
      PCS_BRANCH = 2'b01,
      PCS_JUMP   = 2'b10
   } pcsel_e;

   typedef enum logic [1:0] {
      SRC2_NONE = 2'd0,
      SRC2_RC   = 2'd1,
      SRC2_RA   = 2'd2
   } src2_e;

   // Every opcode except lui reads rB as its first source.
   function automatic logic reads_rb(op_e op);
      return op != OP_LUI;
   endfunction

   // Field carrying the second source operand, if any.
   function automatic src2_e second_src(op_e op);
      case (op)
         OP_ADD, OP_NAND: return SRC2_RC;
         OP_SW, OP_BEQ:   return SRC2_RA;
         default:         return SRC2_NONE;
      endcase
   endfunction

   // Stores and branches leave the register file untouched.
   function automatic logic writes_rf(op_e op);
      return !(op == OP_SW || op == OP_BEQ);
   endfunction

endpackage

// File: rtl/hzc_src_decode.sv
module hzc_src_decode
   import hzc_pkg::*;
#(
   parameter int REG_W = 3
) (
   input  op_e              op_i,
   input  logic [REG_W-1:0] ra_i,
   input  logic [REG_W-1:0] rb_i,
   input  logic [REG_W-1:0] rc_i,
   output logic             s1_vld_o,
   output logic [REG_W-1:0] s1_idx_o,
   output logic             s2_vld_o,
   output logic [REG_W-1:0] s2_idx_o,
   output logic [REG_W-1:0] tgt_o
);

   src2_e s2_kind;

   always_comb begin
      s2_kind  = second_src(op_i);
      s1_vld_o = reads_rb(op_i);
      s1_idx_o = rb_i;
      case (s2_kind)
         SRC2_RC: begin
            s2_vld_o = 1'b1;
            s2_idx_o = rc_i;
         end
         SRC2_RA: begin
            s2_vld_o = 1'b1;
            s2_idx_o = ra_i;
         end
         default: begin
            s2_vld_o = 1'b0;
            s2_idx_o = '0;
         end
      endcase
      tgt_o = writes_rf(op_i) ? ra_i : '0;
   end

endmodule

// File: rtl/hzc_load_use.sv
module hzc_load_use
   import hzc_pkg::*;
#(
   parameter int REG_W            = 3,
   parameter bit SKIP_ZERO_TARGET = 1'b1
) (
   input  op_e              ex_op_i,
   input  logic [REG_W-1:0] ex_rt_i,
   input  logic             s1_vld_i,
   input  logic [REG_W-1:0] s1_idx_i,
   input  logic             s2_vld_i,
   input  logic [REG_W-1:0] s2_idx_i,
   output logic             hazard_o
);

   logic tgt_live;
   logic hit1;
   logic hit2;

   generate
      if (SKIP_ZERO_TARGET) begin : g_skip_r0
         // r0 reads as zero, so a load into it never feeds a consumer.
         assign tgt_live = (ex_rt_i != '0);
      end else begin : g_any_tgt
         assign tgt_live = 1'b1;
      end
   endgenerate

   always_comb begin
      hit1     = s1_vld_i && (s1_idx_i == ex_rt_i);
      hit2     = s2_vld_i && (s2_idx_i == ex_rt_i);
      hazard_o = (ex_op_i == OP_LW) && tgt_live && (hit1 || hit2);
   end

endmodule

// File: rtl/hzc_redirect.sv
module hzc_redirect
   import hzc_pkg::*;
(
   input  op_e    ex_op_i,
   input  logic   ex_eq_i,
   output logic   squash_o,
   output pcsel_e pc_sel_o
);

   always_comb begin
      squash_o = 1'b0;
      pc_sel_o = PCS_SEQ;
      case (ex_op_i)
         OP_BEQ: begin
            if (ex_eq_i) begin
               squash_o = 1'b1;
               pc_sel_o = PCS_BRANCH;
            end
         end
         OP_JALR: begin
            squash_o = 1'b1;
            pc_sel_o = PCS_JUMP;
         end
         default: begin
            squash_o = 1'b0;
            pc_sel_o = PCS_SEQ;
         end
      endcase
   end

endmodule

// File: rtl/hzc_stall_squash_ctl.sv
module hzc_stall_squash_ctl
   import hzc_pkg::*;
#(
   parameter int REG_W            = 3,
   parameter bit SKIP_ZERO_TARGET = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       dec_op,
   input  logic [REG_W-1:0] dec_ra,
   input  logic [REG_W-1:0] dec_rb,
   input  logic [REG_W-1:0] dec_rc,
   input  logic             ex_eq,
   output logic             stall,
   output logic             squash,
   output logic [1:0]       pc_sel,
   output logic [2:0]       ex_op,
   output logic [REG_W-1:0] ex_rt
);

   localparam logic [REG_W-1:0] RT_NONE = '0;

   initial begin : param_chk
      assert (REG_W >= 1 && REG_W <= 8)
         else $error("hzc_stall_squash_ctl: REG_W out of range");
   end

   op_e              dec_op_e;
   op_e              ex_op_q;
   logic [REG_W-1:0] ex_rt_q;
   logic             s1_vld;
   logic [REG_W-1:0] s1_idx;
   logic             s2_vld;
   logic [REG_W-1:0] s2_idx;
   logic [REG_W-1:0] dec_tgt;
   logic             hazard;
   logic             sq;
   pcsel_e           pcs;

   assign dec_op_e = op_e'(dec_op);

   hzc_src_decode #(.REG_W(REG_W)) u_src (
      .op_i     (dec_op_e),
      .ra_i     (dec_ra),
      .rb_i     (dec_rb),
      .rc_i     (dec_rc),
      .s1_vld_o (s1_vld),
      .s1_idx_o (s1_idx),
      .s2_vld_o (s2_vld),
      .s2_idx_o (s2_idx),
      .tgt_o    (dec_tgt)
   );

   hzc_load_use #(.REG_W(REG_W), .SKIP_ZERO_TARGET(SKIP_ZERO_TARGET)) u_lu (
      .ex_op_i  (ex_op_q),
      .ex_rt_i  (ex_rt_q),
      .s1_vld_i (s1_vld),
      .s1_idx_i (s1_idx),
      .s2_vld_i (s2_vld),
      .s2_idx_i (s2_idx),
      .hazard_o (hazard)
   );

   hzc_redirect u_rd (
      .ex_op_i  (ex_op_q),
      .ex_eq_i  (ex_eq),
      .squash_o (sq),
      .pc_sel_o (pcs)
   );

   // Decode/execute opcode and target fields; bubble = add to r0.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ex_op_q <= OP_ADD;
         ex_rt_q <= RT_NONE;
      end else if (hazard || sq) begin
         ex_op_q <= OP_ADD;
         ex_rt_q <= RT_NONE;
      end else begin
         ex_op_q <= dec_op_e;
         ex_rt_q <= dec_tgt;
      end
   end

   assign stall  = hazard;
   assign squash = sq;
   assign pc_sel = pcs;
   assign ex_op  = ex_op_q;
   assign ex_rt  = ex_rt_q;

   // R5
   stall_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> (ex_op == 3'd0 && ex_rt == RT_NONE));

   // R2
   single_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> !stall);

   // R9
   squash_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
      squash |=> (ex_op == 3'd0 && ex_rt == RT_NONE));

   // R6
   no_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_op == 3'd4 || ex_op == 3'd6) |-> ex_rt == RT_NONE);

   // R8
   jump_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_op == 3'd7) |-> (squash && pc_sel == 2'b10));

   // R7
   beq_fallthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_op == 3'd6 && !ex_eq) |-> (!squash && !stall && pc_sel == 2'b00));

endmodule

// File: tb/hzc_stall_squash_ctl_tb.sv
module hzc_stall_squash_ctl_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NV = 19;

   // {ex_op, ex_ra, ex_rb, dec_op, dec_ra, dec_rb, dec_rc, eq, stall, squash, pc_sel}
   localparam logic [25:0] VEC [NV] = '{
      {3'd5,3'd3,3'd1, 3'd0,3'd1,3'd3,3'd2, 1'b0,1'b1,1'b0,2'd0}, // R2 add rB
      {3'd5,3'd3,3'd1, 3'd0,3'd1,3'd2,3'd3, 1'b0,1'b1,1'b0,2'd0}, // R3 add rC
      {3'd5,3'd3,3'd1, 3'd1,3'd1,3'd2,3'd3, 1'b0,1'b0,1'b0,2'd0}, // R3 addi rC ignored
      {3'd5,3'd3,3'd1, 3'd4,3'd3,3'd1,3'd0, 1'b0,1'b1,1'b0,2'd0}, // R3 sw rA
      {3'd5,3'd3,3'd1, 3'd6,3'd3,3'd2,3'd0, 1'b0,1'b1,1'b0,2'd0}, // R3 beq rA
      {3'd5,3'd3,3'd1, 3'd3,3'd1,3'd3,3'd3, 1'b0,1'b0,1'b0,2'd0}, // R2 lui no source
      {3'd5,3'd3,3'd1, 3'd7,3'd3,3'd1,3'd0, 1'b0,1'b0,1'b0,2'd0}, // R3 jalr rA is target
      {3'd5,3'd3,3'd1, 3'd7,3'd1,3'd3,3'd0, 1'b0,1'b1,1'b0,2'd0}, // R2 jalr rB
      {3'd5,3'd0,3'd1, 3'd0,3'd1,3'd0,3'd0, 1'b0,1'b0,1'b0,2'd0}, // R4 load to r0
      {3'd1,3'd3,3'd1, 3'd0,3'd1,3'd3,3'd3, 1'b0,1'b0,1'b0,2'd0}, // R4 not a load
      {3'd6,3'd1,3'd2, 3'd5,3'd5,3'd3,3'd0, 1'b1,1'b0,1'b1,2'd1}, // R7 taken
      {3'd6,3'd1,3'd2, 3'd5,3'd5,3'd3,3'd0, 1'b0,1'b0,1'b0,2'd0}, // R7 not taken
      {3'd7,3'd1,3'd2, 3'd0,3'd4,3'd1,3'd2, 1'b0,1'b0,1'b1,2'd2}, // R8 eq low
      {3'd7,3'd1,3'd2, 3'd0,3'd4,3'd1,3'd2, 1'b1,1'b0,1'b1,2'd2}, // R8 eq high
      {3'd5,3'd4,3'd1, 3'd2,3'd1,3'd4,3'd2, 1'b0,1'b1,1'b0,2'd0}, // R2 nand rB
      {3'd5,3'd4,3'd1, 3'd2,3'd1,3'd2,3'd4, 1'b0,1'b1,1'b0,2'd0}, // R3 nand rC
      {3'd4,3'd3,3'd1, 3'd0,3'd1,3'd3,3'd3, 1'b0,1'b0,1'b0,2'd0}, // R4 store in execute
      {3'd5,3'd6,3'd1, 3'd5,3'd2,3'd1,3'd6, 1'b0,1'b0,1'b0,2'd0}, // R3 lw rC ignored
      {3'd5,3'd7,3'd1, 3'd4,3'd2,3'd7,3'd0, 1'b0,1'b1,1'b0,2'd0}  // R2 sw rB
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] dec_op = '0;
   logic [2:0] dec_ra = '0;
   logic [2:0] dec_rb = '0;
   logic [2:0] dec_rc = '0;
   logic       ex_eq = 1'b0;
   logic       stall;
   logic       squash;
   logic [1:0] pc_sel;
   logic [2:0] ex_op;
   logic [2:0] ex_rt;

   int n_chk = 0;
   int n_err = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hzc_stall_squash_ctl u_dut (
      .clk    (clk),
      .rst_n  (rst_n),
      .dec_op (dec_op),
      .dec_ra (dec_ra),
      .dec_rb (dec_rb),
      .dec_rc (dec_rc),
      .ex_eq  (ex_eq),
      .stall  (stall),
      .squash (squash),
      .pc_sel (pc_sel),
      .ex_op  (ex_op),
      .ex_rt  (ex_rt)
   );

   function automatic logic [2:0] exp_tgt(input logic [2:0] op, input logic [2:0] ra);
      return (op == 3'd4 || op == 3'd6) ? 3'd0 : ra;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [2:0] op, ra, rb, rc, input logic eq);
      dec_op = op; dec_ra = ra; dec_rb = rb; dec_rc = rc; ex_eq = eq;
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 100000);
      n_err++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin : main
      repeat (2) @(posedge clk);
      @(negedge clk);
      #1;
      chk("R1 ex_op at reset", ex_op, 0);
      chk("R1 ex_rt at reset", ex_rt, 0);
      chk("R1 stall at reset", stall, 0);
      chk("R1 squash at reset", squash, 0);
      chk("R1 pc_sel at reset", pc_sel, 0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         logic [25:0] v;
         v = VEC[i];
         @(negedge clk); drive(3'd0, 3'd0, 3'd0, 3'd0, 1'b0);
         @(negedge clk); drive(3'd0, 3'd0, 3'd0, 3'd0, 1'b0);
         @(negedge clk); drive(v[25:23], v[22:20], v[19:17], 3'd0, 1'b0);
         @(negedge clk);
         chk("R6 setup ex_op", ex_op, v[25:23]);
         chk("R6 setup ex_rt", ex_rt, exp_tgt(v[25:23], v[22:20]));
         drive(v[16:14], v[13:11], v[10:8], v[7:5], v[4]);
         #1;
         chk($sformatf("R2 R3 R4 stall vec %0d", i), stall, v[3]);
         chk($sformatf("R7 R8 squash vec %0d", i), squash, v[2]);
         chk($sformatf("R7 R8 R9 pc_sel vec %0d", i), pc_sel, v[1:0]);
         @(negedge clk);
         if (v[3] || v[2]) begin
            chk($sformatf("R5 R9 bubble op vec %0d", i), ex_op, 0);
            chk($sformatf("R5 R9 bubble rt vec %0d", i), ex_rt, 0);
         end else begin
            chk($sformatf("R6 load op vec %0d", i), ex_op, v[16:14]);
            chk($sformatf("R6 load rt vec %0d", i), ex_rt, exp_tgt(v[16:14], v[13:11]));
         end
      end

      // Held decode instruction: one stall, then it proceeds (R2, R5)
      @(negedge clk); drive(3'd0, 3'd0, 3'd0, 3'd0, 1'b0);
      @(negedge clk); drive(3'd5, 3'd2, 3'd1, 3'd0, 1'b0);
      @(negedge clk); drive(3'd0, 3'd1, 3'd2, 3'd0, 1'b0);
      #1;
      chk("R2 first stall", stall, 1);
      @(negedge clk);
      chk("R5 bubble after stall", ex_op, 0);
      chk("R2 stall released", stall, 0);
      @(negedge clk);
      chk("R6 held instr enters op", ex_op, 0);
      chk("R6 held instr enters rt", ex_rt, 1);

      // Reset mid-run with a jump in execute (R1)
      drive(3'd7, 3'd5, 3'd1, 3'd0, 1'b0);
      @(negedge clk);
      chk("R8 jump loaded", ex_op, 7);
      rst_n = 1'b0;
      #1;
      chk("R1 async reset op", ex_op, 0);
      chk("R1 async reset squash", squash, 0);
      @(negedge clk);
      rst_n = 1'b1;

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule